// File: doc/BRIEF.md
# Duty-Cycled Acoustic Wake Trigger

This controller keeps an acoustic front end asleep most of the time and wakes it for one probe. A slow tick input (about 12 kHz) drives a wake counter. On every twentieth tick the controller switches on the microphone supply, the bias offset, the amplifier and the converter. It also switches on the anti-alias filter when that path is configured. It then waits a settling time and asks the converter for one sample.

The probe code is made signed by removing an offset of 520. If the value lies inside an asymmetric quiet window, everything is switched off and the wake counter starts a new period. If the value lies outside the window, the controller emits a one-cycle start pulse and keeps the front end powered. It then enters continuous mode and passes each further conversion out with an offset of 512 removed. It stays there, ignoring ticks, until the downstream analyser signals that it is done.

Top module: `wake_probe_ctrl`

## Requirements
- R1: After reset every output is low.
- R2: Power enables rise in the cycle after the twentieth tick pulse counted since the last arm, and stay low before it.
- R3: During a probe, mic, bias, amplifier and converter enables are high from the wake until the probe ends. The filter enable is high only when the filter path is configured.
- R4: The converter request comes 25 cycles after the wake edge when the filter path is configured, and 8 cycles after it otherwise.
- R5: Each probe makes exactly one request, and the request is one cycle wide.
- R6: The probe value is the 10-bit code minus 520. It triggers when below -40 or at least 90, so codes 480 and 609 are quiet while 479 and 610 trigger.
- R7: A quiet probe clears every enable in the cycle after the sample. A fresh count of twenty ticks is then needed for the next wake.
- R8: A triggering probe gives a one-cycle start pulse in the cycle after the sample. The continuous-mode flag is then set and the enables stay high.
- R9: In continuous mode each valid code yields, one cycle later, a one-cycle sample strobe with value code minus 512 (11-bit two's complement).
- R10: In continuous mode ticks have no effect: no request and no further start pulse.
- R11: A done pulse in continuous mode clears the flag and all enables in the next cycle.
- R12: The filter select is sampled once after reset. Later changes affect neither the settle length nor the filter enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per slow tick |
| aaf_sel_i | input | 1 | Filter path select, captured after reset |
| done_i | input | 1 | Analysis finished, return to armed |
| adc_valid_i | input | 1 | Conversion result valid |
| adc_data_i | input | 10 | Raw conversion code |
| adc_req_o | output | 1 | Single conversion request |
| mic_en_o | output | 1 | Microphone supply enable |
| bias_en_o | output | 1 | Bias offset enable |
| amp_en_o | output | 1 | Amplifier enable |
| filt_en_o | output | 1 | Anti-alias filter enable |
| adc_en_o | output | 1 | Converter enable |
| cont_mode_o | output | 1 | Continuous sampling active |
| start_o | output | 1 | One-cycle start-analysis pulse |
| sample_valid_o | output | 1 | Continuous sample strobe |
| sample_o | output | 11 | Offset-removed continuous sample |

## Verification
The assertions take three things for granted about the inputs. Ticks and valid strobes are single-cycle pulses. The converter answers a request with exactly one valid strobe. The filter select is stable during reset. The stimulus drives each tick and strobe high for one cycle only, and sends a valid only after a request or while in continuous mode. It changes the filter select only after reset has been released, and does so on purpose to show that the change is ignored. Probe codes mix the four window edges and the code extremes with random codes drawn from a fixed seed.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [2:0] {
    ST_ARMED  = 3'd0,
    ST_SETTLE = 3'd1,
    ST_REQ    = 3'd2,
    ST_WAIT   = 3'd3,
    ST_RUN    = 3'd4
  } wake_state_e;
endpackage

// File: rtl/wake_tick_timer.sv
module wake_tick_timer #(
  parameter int unsigned PERIOD = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  input  logic tick_i,
  output logic wake_o
);
  localparam int unsigned CW = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign wake_o = en_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || wake_o)   cnt_q <= '0;
    else if (en_i && tick_i)    cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/wake_settle_timer.sv
module wake_settle_timer #(
  parameter int unsigned LEN_FILT   = 25,
  parameter int unsigned LEN_DIRECT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic filt_i,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned MAXL = (LEN_FILT > LEN_DIRECT) ? LEN_FILT : LEN_DIRECT;
  localparam int unsigned CW   = $clog2(MAXL + 1);

  logic [CW-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= filt_i ? CW'(LEN_FILT - 1) : CW'(LEN_DIRECT - 1);
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/probe_window.sv
module probe_window #(
  parameter int unsigned ADC_W  = 10,
  parameter int          OFS    = 520,
  parameter int          LVL_LO = -40,
  parameter int          LVL_HI = 90
) (
  input  logic [ADC_W-1:0] code_i,
  output logic             trig_o
);
  localparam int SW = ADC_W + 2;

  logic signed [SW-1:0] val;

  always_comb begin
    val    = $signed({2'b00, code_i}) - SW'(OFS);
    trig_o = (val < SW'(LVL_LO)) || (val >= SW'(LVL_HI));
  end
endmodule

// File: rtl/wake_probe_ctrl.sv
module wake_probe_ctrl
  import wake_pkg::*;
#(
  parameter int unsigned ADC_W      = 10,
  parameter int unsigned WAKE_TICKS = 20,
  parameter int unsigned SETTLE_AAF = 25,
  parameter int unsigned SETTLE_DIR = 8,
  parameter int          PROBE_OFS  = 520,
  parameter int          CONT_OFS   = 512,
  parameter int          LVL_LO     = -40,
  parameter int          LVL_HI     = 90
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             aaf_sel_i,
  input  logic             done_i,
  input  logic             adc_valid_i,
  input  logic [ADC_W-1:0] adc_data_i,
  output logic             adc_req_o,
  output logic             mic_en_o,
  output logic             bias_en_o,
  output logic             amp_en_o,
  output logic             filt_en_o,
  output logic             adc_en_o,
  output logic             cont_mode_o,
  output logic             start_o,
  output logic             sample_valid_o,
  output logic [ADC_W:0]   sample_o
);
  localparam int unsigned OW = ADC_W + 1;

  wake_state_e state_q, state_d;
  logic cfg_done_q, aaf_q;
  logic wake, settle_done, trig, start_q;
  logic svalid_q;
  logic [OW-1:0] sample_q;

  // filter config captured on the first clock after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_done_q <= 1'b0;
      aaf_q      <= 1'b0;
    end else if (!cfg_done_q) begin
      cfg_done_q <= 1'b1;
      aaf_q      <= aaf_sel_i;
    end
  end

  wake_tick_timer #(.PERIOD(WAKE_TICKS)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_ARMED),
    .clr_i  (state_q != ST_ARMED),
    .tick_i (tick_i),
    .wake_o (wake)
  );

  wake_settle_timer #(.LEN_FILT(SETTLE_AAF), .LEN_DIRECT(SETTLE_DIR)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wake),
    .filt_i (aaf_q),
    .run_i  (state_q == ST_SETTLE),
    .done_o (settle_done)
  );

  probe_window #(.ADC_W(ADC_W), .OFS(PROBE_OFS), .LVL_LO(LVL_LO), .LVL_HI(LVL_HI)) u_win (
    .code_i (adc_data_i),
    .trig_o (trig)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ARMED:  if (wake)        state_d = ST_SETTLE;
      ST_SETTLE: if (settle_done) state_d = ST_REQ;
      ST_REQ:                     state_d = ST_WAIT;
      ST_WAIT:   if (adc_valid_i) state_d = trig ? ST_RUN : ST_ARMED;
      ST_RUN:    if (done_i)      state_d = ST_ARMED;
      default:                    state_d = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_ARMED;
      start_q  <= 1'b0;
      svalid_q <= 1'b0;
      sample_q <= '0;
    end else begin
      state_q  <= state_d;
      start_q  <= (state_q == ST_WAIT) && adc_valid_i && trig;
      svalid_q <= (state_q == ST_RUN) && adc_valid_i;
      if ((state_q == ST_RUN) && adc_valid_i)
        sample_q <= {1'b0, adc_data_i} - OW'(CONT_OFS);
    end
  end

  logic powered;
  assign powered        = (state_q != ST_ARMED);
  assign mic_en_o       = powered;
  assign bias_en_o      = powered;
  assign amp_en_o       = powered;
  assign adc_en_o       = powered;
  assign filt_en_o      = powered && aaf_q;
  assign adc_req_o      = (state_q == ST_REQ);
  assign cont_mode_o    = (state_q == ST_RUN);
  assign start_o        = start_q;
  assign sample_valid_o = svalid_q;
  assign sample_o       = sample_q;

  p_req_powered_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_req_o |-> (mic_en_o && bias_en_o && amp_en_o && adc_en_o));
  p_filt_needs_amp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt_en_o |-> amp_en_o);
  p_req_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_req_o |=> !adc_req_o);
  p_start_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  p_start_cont_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (cont_mode_o && mic_en_o));
  p_no_req_cont_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cont_mode_o |-> !adc_req_o);
  p_done_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cont_mode_o && done_i) |=> (!cont_mode_o && !mic_en_o));
  p_svalid_cont_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |-> $past(cont_mode_o));
endmodule

// File: tb/tb_wake_probe_ctrl.sv
module tb_wake_probe_ctrl;
  localparam int WAKE = 20, S_AAF = 25, S_DIR = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tick_i = 0, aaf_sel_i = 0, done_i = 0, adc_valid_i = 0;
  logic [9:0] adc_data_i = '0;
  logic adc_req_o, mic_en_o, bias_en_o, amp_en_o, filt_en_o, adc_en_o;
  logic cont_mode_o, start_o, sample_valid_o;
  logic [10:0] sample_o;
  int total = 0, bad = 0;
  logic aaf_cfg;

  always #4 clk = ~clk;

  wake_probe_ctrl #(.WAKE_TICKS(WAKE), .SETTLE_AAF(S_AAF), .SETTLE_DIR(S_DIR)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .aaf_sel_i(aaf_sel_i),
    .done_i(done_i), .adc_valid_i(adc_valid_i), .adc_data_i(adc_data_i),
    .adc_req_o(adc_req_o), .mic_en_o(mic_en_o), .bias_en_o(bias_en_o),
    .amp_en_o(amp_en_o), .filt_en_o(filt_en_o), .adc_en_o(adc_en_o),
    .cont_mode_o(cont_mode_o), .start_o(start_o),
    .sample_valid_o(sample_valid_o), .sample_o(sample_o));

  function automatic bit exp_trig(input int code);
    int v = code - 520;
    return (v < -40) || (v >= 90);
  endfunction

  function automatic logic [10:0] exp_sample(input int code);
    return 11'(code - 512);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_tick();
    tick_i = 1; @(negedge clk); tick_i = 0; @(negedge clk);
  endtask

  task automatic do_reset(input logic aaf);
    rst_ni = 0; aaf_sel_i = aaf; aaf_cfg = aaf;
    repeat (3) @(negedge clk);
    rst_ni = 1; @(negedge clk);
  endtask

  task automatic probe(input int code);
    int n = 0;
    for (int i = 0; i < WAKE - 1; i++) pulse_tick();
    chk(mic_en_o == 0, "R2 early wake", mic_en_o, 0);
    tick_i = 1; @(negedge clk); tick_i = 0;
    chk({mic_en_o, bias_en_o, amp_en_o, adc_en_o} == 4'hf, "R3 enables", mic_en_o, 1);
    chk(filt_en_o == aaf_cfg, "R12 filter enable", filt_en_o, aaf_cfg);
    while (!adc_req_o && n < 100) begin @(posedge clk); n++; @(negedge clk); end
    chk(n == (aaf_cfg ? S_AAF : S_DIR), "R4 settle", n, aaf_cfg ? S_AAF : S_DIR);
    @(negedge clk);
    chk(adc_req_o == 0 && mic_en_o == 1, "R5 req width", adc_req_o, 0);
    adc_valid_i = 1; adc_data_i = 10'(code); @(negedge clk); adc_valid_i = 0;
    if (exp_trig(code)) begin
      chk(start_o == 1 && cont_mode_o == 1, "R6 R8 trigger", start_o, 1);
      chk(mic_en_o == 1 && adc_en_o == 1, "R8 stay powered", mic_en_o, 1);
      @(negedge clk);
      chk(start_o == 0, "R8 start width", start_o, 0);
    end else begin
      chk(start_o == 0 && cont_mode_o == 0, "R6 quiet", start_o, 0);
      chk({mic_en_o, bias_en_o, amp_en_o, adc_en_o, filt_en_o} == 0, "R7 power down",
          mic_en_o, 0);
    end
  endtask

  task automatic run_phase();
    int code;
    bit seen = 0;
    for (int i = 0; i < 4; i++) begin
      code = (i == 0) ? 0 : (i == 1) ? 1023 : int'($urandom_range(1023));
      adc_valid_i = 1; adc_data_i = 10'(code); @(negedge clk); adc_valid_i = 0;
      chk(sample_valid_o == 1 && sample_o == exp_sample(code), "R9 sample",
          int'(sample_o), int'(exp_sample(code)));
      @(negedge clk);
    end
    for (int i = 0; i < WAKE + 5; i++) begin
      tick_i = 1; @(negedge clk); tick_i = 0;
      if (adc_req_o || start_o || !cont_mode_o) seen = 1;
      @(negedge clk);
      if (adc_req_o || start_o || !cont_mode_o) seen = 1;
    end
    chk(!seen, "R10 ticks ignored", seen, 0);
    done_i = 1; @(negedge clk); done_i = 0;
    chk(cont_mode_o == 0 && mic_en_o == 0 && adc_en_o == 0, "R11 done", cont_mode_o, 0);
  endtask

  task automatic probe_full(input int code);
    probe(code);
    if (exp_trig(code)) run_phase();
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset(1'b0);
    chk({adc_req_o, mic_en_o, bias_en_o, amp_en_o, filt_en_o, adc_en_o, cont_mode_o,
         start_o, sample_valid_o} == 0 && sample_o == 0, "R1 reset", mic_en_o, 0);
    aaf_sel_i = 1;  // R12: change after capture must be ignored
    probe_full(480);
    probe_full(479);
    probe_full(609);
    probe_full(610);
    probe_full(0);
    probe_full(1023);
    for (int i = 0; i < 6; i++) probe_full(int'($urandom_range(1023)));
    do_reset(1'b1);
    aaf_sel_i = 0;
    probe_full(500);
    probe_full(700);
    probe_full(int'($urandom_range(1023)));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule